// File: doc/BRIEF.md
# Two-Wire Controller FIFO Register Bank

This block is the byte-wide control and status bank that a two-wire bus controller uses in its buffered (FIFO) mode. Software reaches it through a single-cycle register port that carries an address, a write strobe and write data. Read data is returned combinationally for the presented address. The bank holds eight registers: FIFO control, FIFO control/status, transmit control, transmit status, timeout, fairness period, receive status and receive control.

The bus engine drives event inputs into the bank. These report a START that won the bus, the address phase of a write, a byte sent successfully together with the current transmit count, and a receive-threshold hit. The bank turns these into sticky flags and a transmit-threshold status. It merges three enable/status pairs into one interrupt level. External logic also drives a busy level, a ready pulse, a stall pulse and a timeout pulse, so that the read-only and hold-until-cleared bits can be observed.

Top module: `twi_fifo_regs`

## Requirements
- R1: Register offsets are 0x0 FIFO control, 0x1 control/status, 0x2 transmit control, 0x3 transmit status, 0x4 timeout, 0x5 fairness, 0x6 receive status and 0x7 receive control. After reset every register reads 0x00, except timeout, which reads 0x3F, and receive control, which reads 0x01.
- R2: In FIFO control, bits 7:2 are read/write, and bit 4 drives `fifo_en_o`. Bit 1 is a ready flag set by `ready_set_i` and cleared by writing 1. Bit 0 shows `busy_i` one cycle late, and writes do not change it.
- R3: In control/status, bit 7 is a stall flag set by `str_set_i`. Bit 1 is the buffer event flag. Both clear only when written with 1. Bit 3 is a read/write event interrupt enable. All other bits read 0.
- R4: Writing control/status with bit 6 set clears the event flag and zeroes transmit status and receive status. This clear takes priority over any hardware set in the same cycle.
- R5: When a hardware set and a write-one-to-clear reach the same flag in the same cycle, the flag ends up set.
- R6: While `fifo_en_o` and `ctl_en_i` are both high, each pulse on `start_won_i`, `wr_addr_i` or `byte_sent_i` sets the event flag.
- R7: On `byte_sent_i` in FIFO mode, transmit status becomes 0x40 when `tx_cnt_i` equals transmit control bits 4:0, and 0x00 otherwise. A byte sent has priority over a clear of bit 6 written in the same cycle. Bit 6 clears when written with 1. When FIFO mode is off, `byte_sent_i` has no effect. Transmit control is plain read/write, with bit 6 as its interrupt enable.
- R8: In the timeout register, bits 6:0 are read/write. Bit 7 is set by `to_set_i` and clears only when written with 1; writing 0 to it leaves it set.
- R9: Receive status bit 6 is set by `rx_thr_set_i` and clears when written with 1. Receive control is read/write, with bit 6 as its interrupt enable.
- R10: `irq_o` is high exactly when at least one of three pairs is active: receive enable with receive status bit 6, transmit enable with transmit status bit 6, or event enable with the event flag.
- R11: While `ctl_en_i` is low, the event flag, transmit status and receive status are held at zero. The other registers keep their contents.
- R12: The fairness register is plain read/write. Offsets 0x8 to 0xF read 0x00, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctl_en_i | input | 1 | Controller enable; low clears FIFO state |
| wr_i | input | 1 | Register write strobe |
| addr_i | input | 4 | Register offset |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i |
| busy_i | input | 1 | Busy level mirrored into FIFO control bit 0 |
| ready_set_i | input | 1 | Sets the ready flag |
| str_set_i | input | 1 | Sets the stall flag |
| start_won_i | input | 1 | START won the bus |
| wr_addr_i | input | 1 | Address phase of a write transfer done |
| byte_sent_i | input | 1 | Byte sent successfully |
| tx_cnt_i | input | 5 | Transmit byte count presented with byte_sent_i |
| rx_thr_set_i | input | 1 | Receive threshold reached |
| to_set_i | input | 1 | Timeout detected |
| fifo_en_o | output | 1 | FIFO mode enable |
| irq_o | output | 1 | Combined FIFO interrupt |

## Verification
A software write-one-to-clear and a hardware set can land on the same flag in the same cycle. The same is true of the clear-FIFO command and a START or threshold event. The bench raises the event input and issues the register write on the same clock edge. It then reads the register back on the following cycle. A flag that received both a set and a write-one-to-clear must read set. Any flag reached by the clear-FIFO command must read zero, whatever event arrived with it.

// File: rtl/twi_fifo_pkg.sv
package twi_fifo_pkg;
  localparam int DW   = 8;
  localparam int NREG = 8;
  localparam int OW   = $clog2(NREG);

  localparam logic [OW-1:0] OFF_FCTL = 3'd0;
  localparam logic [OW-1:0] OFF_FCS  = 3'd1;
  localparam logic [OW-1:0] OFF_TXC  = 3'd2;
  localparam logic [OW-1:0] OFF_TXS  = 3'd3;
  localparam logic [OW-1:0] OFF_TMO  = 3'd4;
  localparam logic [OW-1:0] OFF_FAIR = 3'd5;
  localparam logic [OW-1:0] OFF_RXS  = 3'd6;
  localparam logic [OW-1:0] OFF_RXC  = 3'd7;

  localparam int B_FCTL_EN  = 4;
  localparam int B_FCTL_RDY = 1;
  localparam int B_FCS_STR  = 7;
  localparam int B_FCS_CLR  = 6;
  localparam int B_FCS_IE   = 3;
  localparam int B_FCS_EV   = 1;
  localparam int B_THR      = 6;
  localparam int B_TMO_ST   = 7;

  localparam logic [DW-1:0] RST_TMO = 8'h3F;
  localparam logic [DW-1:0] RST_RXC = 8'h01;

  typedef enum int {FL_RDY = 0, FL_STR = 1, FL_EV = 2, FL_RXT = 3, FL_TMO = 4} flag_e;
  localparam int NFLG = 5;
endpackage

// File: rtl/twi_fifo_flag.sv
module twi_fifo_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic set_i,
  input  logic w1c_i,
  output logic q_o
);
  // priority: clear command > hardware set > software write-one-clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q_o <= 1'b0;
    else if (clr_i) q_o <= 1'b0;
    else if (set_i) q_o <= 1'b1;
    else if (w1c_i) q_o <= 1'b0;
  end
endmodule

// File: rtl/twi_fifo_irq.sv
module twi_fifo_irq #(
  parameter int NSRC = 3
) (
  input  logic [NSRC-1:0] en_i,
  input  logic [NSRC-1:0] st_i,
  output logic            irq_o
);
  assign irq_o = |(en_i & st_i);
endmodule

// File: rtl/twi_fifo_regs.sv
module twi_fifo_regs
  import twi_fifo_pkg::*;
#(
  parameter int AW = 4,
  parameter int CW = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ctl_en_i,
  input  logic          wr_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  input  logic          busy_i,
  input  logic          ready_set_i,
  input  logic          str_set_i,
  input  logic          start_won_i,
  input  logic          wr_addr_i,
  input  logic          byte_sent_i,
  input  logic [CW-1:0] tx_cnt_i,
  input  logic          rx_thr_set_i,
  input  logic          to_set_i,
  output logic          fifo_en_o,
  output logic          irq_o
);
  localparam int NSRC = 3;

  logic            mapped;
  logic [NREG-1:0] wr_sel;
  logic [DW-1:2]   fctl_hi_q;
  logic            busy_q, fcs_ie_q, txt_q;
  logic [DW-1:0]   txc_q, fair_q, rxc_q;
  logic [DW-2:0]   tmo_lo_q;
  logic            fifo_clr;
  logic [NFLG-1:0] flg_set, flg_w1c, flg_clr, flg_q;
  logic            ev_q, rxt_q, tmo_q;

  assign mapped = (addr_i < AW'(NREG));

  always_comb begin
    wr_sel = '0;
    if (wr_i && mapped) wr_sel[addr_i[OW-1:0]] = 1'b1;
  end

  assign fifo_en_o = fctl_hi_q[B_FCTL_EN];
  assign fifo_clr  = !ctl_en_i || (wr_sel[OFF_FCS] && wdata_i[B_FCS_CLR]);

  always_comb begin
    flg_set = '0;
    flg_w1c = '0;
    flg_clr = '0;
    flg_set[FL_RDY] = ready_set_i;
    flg_set[FL_STR] = str_set_i;
    flg_set[FL_EV]  = fifo_en_o && ctl_en_i && (start_won_i || wr_addr_i || byte_sent_i);
    flg_set[FL_RXT] = rx_thr_set_i;
    flg_set[FL_TMO] = to_set_i;
    flg_w1c[FL_RDY] = wr_sel[OFF_FCTL] && wdata_i[B_FCTL_RDY];
    flg_w1c[FL_STR] = wr_sel[OFF_FCS]  && wdata_i[B_FCS_STR];
    flg_w1c[FL_EV]  = wr_sel[OFF_FCS]  && wdata_i[B_FCS_EV];
    flg_w1c[FL_RXT] = wr_sel[OFF_RXS]  && wdata_i[B_THR];
    flg_w1c[FL_TMO] = wr_sel[OFF_TMO]  && wdata_i[B_TMO_ST];
    flg_clr[FL_EV]  = fifo_clr;
    flg_clr[FL_RXT] = fifo_clr;
  end

  for (genvar g = 0; g < NFLG; g++) begin : g_flag
    twi_fifo_flag u_flag (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (flg_clr[g]),
      .set_i  (flg_set[g]),
      .w1c_i  (flg_w1c[g]),
      .q_o    (flg_q[g])
    );
  end

  assign ev_q  = flg_q[FL_EV];
  assign rxt_q = flg_q[FL_RXT];
  assign tmo_q = flg_q[FL_TMO];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fctl_hi_q <= '0;
      busy_q    <= 1'b0;
      fcs_ie_q  <= 1'b0;
      txc_q     <= '0;
      tmo_lo_q  <= RST_TMO[DW-2:0];
      fair_q    <= '0;
      rxc_q     <= RST_RXC;
    end else begin
      busy_q <= busy_i;
      if (wr_sel[OFF_FCTL]) fctl_hi_q <= wdata_i[DW-1:2];
      if (wr_sel[OFF_FCS])  fcs_ie_q  <= wdata_i[B_FCS_IE];
      if (wr_sel[OFF_TXC])  txc_q     <= wdata_i;
      if (wr_sel[OFF_TMO])  tmo_lo_q  <= wdata_i[DW-2:0];
      if (wr_sel[OFF_FAIR]) fair_q    <= wdata_i;
      if (wr_sel[OFF_RXC])  rxc_q     <= wdata_i;
    end
  end

  // transmit threshold status: a send reloads it, a write-one clears it
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                  txt_q <= 1'b0;
    else if (fifo_clr)                            txt_q <= 1'b0;
    else if (byte_sent_i && fifo_en_o)            txt_q <= (tx_cnt_i == txc_q[CW-1:0]);
    else if (wr_sel[OFF_TXS] && wdata_i[B_THR])   txt_q <= 1'b0;
  end

  twi_fifo_irq #(.NSRC(NSRC)) u_irq (
    .en_i  ({rxc_q[B_THR], txc_q[B_THR], fcs_ie_q}),
    .st_i  ({rxt_q, txt_q, ev_q}),
    .irq_o (irq_o)
  );

  always_comb begin
    rdata_o = '0;
    if (mapped) begin
      case (addr_i[OW-1:0])
        OFF_FCTL: rdata_o = {fctl_hi_q, flg_q[FL_RDY], busy_q};
        OFF_FCS:  rdata_o = {flg_q[FL_STR], 3'b000, fcs_ie_q, 1'b0, ev_q, 1'b0};
        OFF_TXC:  rdata_o = txc_q;
        OFF_TXS:  rdata_o = {1'b0, txt_q, 6'b0};
        OFF_TMO:  rdata_o = {tmo_q, tmo_lo_q};
        OFF_FAIR: rdata_o = fair_q;
        OFF_RXS:  rdata_o = {1'b0, rxt_q, 6'b0};
        default:  rdata_o = rxc_q;
      endcase
    end
  end
endmodule

// File: rtl/twi_fifo_regs_chk.sv
module twi_fifo_regs_chk #(
  parameter int AW = 4
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          ctl_en_i,
  input logic          wr_i,
  input logic [AW-1:0] addr_i,
  input logic [7:0]    wdata_i,
  input logic          busy_i,
  input logic          start_won_i,
  input logic          to_set_i,
  input logic          fifo_en_o,
  input logic          irq_o,
  input logic          busy_q,
  input logic          ev_q,
  input logic          txt_q,
  input logic          rxt_q,
  input logic          tmo_q
);
  logic clr_cmd, tmo_w1c;
  assign clr_cmd = wr_i && (addr_i == AW'(1)) && wdata_i[6];
  assign tmo_w1c = wr_i && (addr_i == AW'(4)) && wdata_i[7];

  a_r2_busy_mirror: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> busy_q == $past(busy_i));

  a_r6_event_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_en_i && fifo_en_o && start_won_i && !clr_cmd) |=> ev_q);

  a_r11_disable_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctl_en_i |=> (!ev_q && !txt_q && !rxt_q));

  a_r8_timeout_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tmo_q && !tmo_w1c) |=> tmo_q);

  a_r5_timeout_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    to_set_i |=> tmo_q);

  a_r10_irq_needs_status: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ev_q && !txt_q && !rxt_q) |-> !irq_o);
endmodule

bind twi_fifo_regs twi_fifo_regs_chk #(.AW(AW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .ctl_en_i    (ctl_en_i),
  .wr_i        (wr_i),
  .addr_i      (addr_i),
  .wdata_i     (wdata_i),
  .busy_i      (busy_i),
  .start_won_i (start_won_i),
  .to_set_i    (to_set_i),
  .fifo_en_o   (fifo_en_o),
  .irq_o       (irq_o),
  .busy_q      (busy_q),
  .ev_q        (ev_q),
  .txt_q       (txt_q),
  .rxt_q       (rxt_q),
  .tmo_q       (tmo_q)
);

// File: tb/twi_fifo_regs_bench.sv
`timescale 1ns/1ps
module twi_fifo_regs_bench;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       ctl_en_i = 1'b1;
  logic       wr_i = 1'b0;
  logic [3:0] addr_i = '0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o;
  logic       busy_i = 1'b0, ready_set_i = 1'b0, str_set_i = 1'b0;
  logic       start_won_i = 1'b0, wr_addr_i = 1'b0, byte_sent_i = 1'b0;
  logic [4:0] tx_cnt_i = '0;
  logic       rx_thr_set_i = 1'b0, to_set_i = 1'b0;
  logic       fifo_en_o, irq_o;

  always #2.5 clk = ~clk;

  twi_fifo_regs u_twi_fifo_regs (
    .clk_i(clk), .rst_ni(rst_ni), .ctl_en_i(ctl_en_i), .wr_i(wr_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .busy_i(busy_i),
    .ready_set_i(ready_set_i), .str_set_i(str_set_i), .start_won_i(start_won_i),
    .wr_addr_i(wr_addr_i), .byte_sent_i(byte_sent_i), .tx_cnt_i(tx_cnt_i),
    .rx_thr_set_i(rx_thr_set_i), .to_set_i(to_set_i), .fifo_en_o(fifo_en_o),
    .irq_o(irq_o)
  );

  typedef struct {
    int         kind;   // 0 rdata, 1 irq, 2 fifo_en
    logic [7:0] exp;
    string      tag;
  } item_t;

  item_t q[$];
  logic  mon_req = 1'b0;
  int    checks = 0;
  int    errors = 0;
  bit    done = 0;

  // monitor: samples mid-cycle, away from the clock edge
  always @(negedge clk) begin
    item_t it;
    logic [7:0] act;
    #1;
    if (mon_req && q.size() > 0) begin
      it = q.pop_front();
      case (it.kind)
        0:       act = rdata_o;
        1:       act = {7'b0, irq_o};
        default: act = {7'b0, fifo_en_o};
      endcase
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s: actual=%02h expected=%02h", it.tag, act, it.exp);
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    addr_i = a; wdata_i = d; wr_i = 1'b1;
    @(negedge clk);
    wr_i = 1'b0;
  endtask

  task automatic expect_item(input int kind, input logic [3:0] a,
                             input logic [7:0] e, input string tag);
    item_t it;
    it.kind = kind; it.exp = e; it.tag = tag;
    addr_i = a;
    q.push_back(it);
    mon_req = 1'b1;
    @(negedge clk);
    mon_req = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [7:0] e, input string tag);
    expect_item(0, a, e, tag);
  endtask

  task automatic irq_chk(input logic e, input string tag);
    expect_item(1, addr_i, {7'b0, e}, tag);
  endtask

  task automatic en_chk(input logic e, input string tag);
    expect_item(2, addr_i, {7'b0, e}, tag);
  endtask

  task automatic send(input logic [4:0] cnt);
    tx_cnt_i = cnt; byte_sent_i = 1'b1;
    tick(1);
    byte_sent_i = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    tick(3);
    rst_ni = 1'b1;
    tick(1);
    // R1 reset values
    rd(4'h0, 8'h00, "R1 fctl"); rd(4'h1, 8'h00, "R1 fcs");
    rd(4'h2, 8'h00, "R1 txc");  rd(4'h3, 8'h00, "R1 txs");
    rd(4'h4, 8'h3F, "R1 tmo");  rd(4'h5, 8'h00, "R1 fair");
    rd(4'h6, 8'h00, "R1 rxs");  rd(4'h7, 8'h01, "R1 rxc");
    irq_chk(1'b0, "R1 irq");
    // R12 unmapped and fairness
    wr(4'h9, 8'hFF); rd(4'h9, 8'h00, "R12 unmapped read");
    rd(4'h1, 8'h00, "R12 no alias write");
    wr(4'h5, 8'hA5); rd(4'h5, 8'hA5, "R12 fair rw");
    // R2 FIFO control
    wr(4'h0, 8'hFF); rd(4'h0, 8'hFC, "R2 rw bits");
    en_chk(1'b1, "R2 fifo_en");
    ready_set_i = 1'b1; tick(1); ready_set_i = 1'b0;
    rd(4'h0, 8'hFE, "R2 ready set");
    busy_i = 1'b1; tick(1);
    rd(4'h0, 8'hFF, "R2 busy mirror");
    wr(4'h0, 8'h10); rd(4'h0, 8'h13, "R2 ready holds on 0");
    wr(4'h0, 8'h12); rd(4'h0, 8'h11, "R2 ready w1c");
    busy_i = 1'b0;
    wr(4'h0, 8'h11); rd(4'h0, 8'h10, "R2 busy not writable");
    // R6 / R3 event flag and stall flag
    start_won_i = 1'b1; tick(1); start_won_i = 1'b0;
    rd(4'h1, 8'h02, "R6 start sets event");
    wr(4'h1, 8'h02); rd(4'h1, 8'h00, "R3 event w1c");
    wr_addr_i = 1'b1; tick(1); wr_addr_i = 1'b0;
    rd(4'h1, 8'h02, "R6 write addr sets event");
    wr(4'h1, 8'h08); rd(4'h1, 8'h0A, "R3 ie rw, event holds");
    irq_chk(1'b1, "R10 event irq");
    wr(4'h1, 8'h0A); rd(4'h1, 8'h08, "R3 event cleared");
    irq_chk(1'b0, "R10 event irq off");
    str_set_i = 1'b1; tick(1); str_set_i = 1'b0;
    rd(4'h1, 8'h88, "R3 stall set");
    wr(4'h1, 8'h88); rd(4'h1, 8'h08, "R3 stall w1c");
    send(5'd1);
    rd(4'h1, 8'h0A, "R6 byte sent sets event");
    wr(4'h1, 8'h0A);
    // R5 set beats w1c
    start_won_i = 1'b1; wr(4'h1, 8'h0A); start_won_i = 1'b0;
    rd(4'h1, 8'h0A, "R5 set beats w1c");
    wr(4'h1, 8'h0A); rd(4'h1, 8'h08, "R5 later w1c clears");
    // R7 transmit threshold
    wr(4'h1, 8'h02); rd(4'h1, 8'h00, "R3 ie off");
    wr(4'h2, 8'h43); rd(4'h2, 8'h43, "R7 txc rw");
    send(5'd3); rd(4'h3, 8'h40, "R7 match");
    irq_chk(1'b1, "R10 tx irq");
    send(5'd2); rd(4'h3, 8'h00, "R7 mismatch");
    irq_chk(1'b0, "R10 tx irq off");
    send(5'd3);
    wr(4'h3, 8'h00); rd(4'h3, 8'h40, "R7 write 0 holds");
    wr(4'h3, 8'h40); rd(4'h3, 8'h00, "R7 w1c");
    tx_cnt_i = 5'd3; byte_sent_i = 1'b1; wr(4'h3, 8'h40); byte_sent_i = 1'b0;
    rd(4'h3, 8'h40, "R7 send beats w1c");
    wr(4'h3, 8'h40);
    wr(4'h0, 8'h00); en_chk(1'b0, "R2 fifo off");
    wr(4'h1, 8'h02);
    send(5'd3);
    rd(4'h3, 8'h00, "R7 ignored fifo off");
    rd(4'h1, 8'h00, "R7 no event fifo off");
    wr(4'h0, 8'h10);
    // R8 timeout
    to_set_i = 1'b1; tick(1); to_set_i = 1'b0;
    rd(4'h4, 8'hBF, "R8 status set");
    wr(4'h4, 8'h05); rd(4'h4, 8'h85, "R8 write 0 keeps status");
    wr(4'h4, 8'h80); rd(4'h4, 8'h00, "R8 w1c");
    to_set_i = 1'b1; wr(4'h4, 8'h80); to_set_i = 1'b0;
    rd(4'h4, 8'h80, "R5 timeout set wins");
    wr(4'h4, 8'hFF); rd(4'h4, 8'h7F, "R8 clear and low bits");
    // R9 receive
    rx_thr_set_i = 1'b1; tick(1); rx_thr_set_i = 1'b0;
    rd(4'h6, 8'h40, "R9 rx status set");
    wr(4'h7, 8'h40); rd(4'h7, 8'h40, "R9 rxc rw");
    irq_chk(1'b1, "R10 rx irq");
    wr(4'h6, 8'h00); rd(4'h6, 8'h40, "R9 write 0 holds");
    wr(4'h6, 8'h40); rd(4'h6, 8'h00, "R9 w1c");
    irq_chk(1'b0, "R10 rx irq off");
    // R4 clear command beats sets
    start_won_i = 1'b1; tick(1); start_won_i = 1'b0;
    rx_thr_set_i = 1'b1; tick(1); rx_thr_set_i = 1'b0;
    send(5'd3);
    rd(4'h3, 8'h40, "R4 precondition tx");
    start_won_i = 1'b1; rx_thr_set_i = 1'b1;
    wr(4'h1, 8'h48);
    start_won_i = 1'b0; rx_thr_set_i = 1'b0;
    rd(4'h1, 8'h08, "R4 event cleared");
    rd(4'h3, 8'h00, "R4 tx status cleared");
    rd(4'h6, 8'h00, "R4 rx status cleared");
    // R11 controller disable
    start_won_i = 1'b1; tick(1); start_won_i = 1'b0;
    rx_thr_set_i = 1'b1; tick(1); rx_thr_set_i = 1'b0;
    send(5'd3);
    ctl_en_i = 1'b0; tick(1);
    rd(4'h1, 8'h08, "R11 event cleared");
    rd(4'h3, 8'h00, "R11 tx cleared");
    rd(4'h6, 8'h00, "R11 rx cleared");
    rd(4'h5, 8'hA5, "R11 fair kept");
    rd(4'h7, 8'h40, "R11 rxc kept");
    start_won_i = 1'b1; tick(1); start_won_i = 1'b0;
    rd(4'h1, 8'h08, "R11 held while disabled");
    irq_chk(1'b0, "R11 irq low");
    ctl_en_i = 1'b1;
    tick(2);
    if (q.size() != 0) begin
      errors++;
      $display("FAIL scoreboard: actual=%0d expected=0 pending", q.size());
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule